// File: doc/BRIEF.md
# Pulsed-Trigger Sensor Capture Controller

This block connects a slow, one-way sensor to fast fabric logic. It divides the system clock down to a sensor clock that stays at or below a set rate. On that clock it sends the sensor a measurement request that lasts exactly one sensor period. It then watches the sensor's valid flag and takes in the parallel reading. Every good reading appears at the fabric side as a 7-bit value with a one-cycle strobe. A reading that never becomes valid within a bounded window is reported with a one-cycle error strobe.

Measurements run back to back. As soon as one completes, whether good or timed out, the next request goes out on the following falling edge of the sensor clock. The request only changes on falling edges of the sensor clock. The valid flag and the data bus pass through a two-flop synchronizer and are sampled on rising edges. Both edges are found in the system-clock domain by comparing the divided clock with a delayed copy of itself.

Top module: `sensor_capture_ctrl`

## Requirements
- R1: The sensor clock has a 50% duty cycle. It stays high for exactly HALF_PERIOD system cycles and low for exactly HALF_PERIOD system cycles. A parameter set that would push it above MAX_SNS_HZ fails elaboration.
- R2: While rst_ni is low, the sensor clock, the request, both strobes and the reading register are all 0. The first request goes high at the 2*HALF_PERIOD+1st rising system-clock edge after reset is released.
- R3: The request stays high for exactly 2*HALF_PERIOD system cycles, which is one sensor period. It rises and falls only right after a falling edge of the sensor clock.
- R4: A high synchronized valid flag seen at any of the first MAX_WAIT rising sensor-clock edges after the request drops is a good reading. On that reading, rd_data_o takes data bits [6:0] and rd_valid_o is high for one system cycle.
- R5: Bit 7 of the sensor data bus never affects rd_data_o.
- R6: rd_data_o changes only in a cycle where rd_valid_o is high. Bus contents while the valid flag is low are ignored.
- R7: If the valid flag is still low after MAX_WAIT rising sensor-clock edges (default 4), rd_err_o pulses for one system cycle and no reading is taken.
- R8: After a good reading or a timeout, the next request rises exactly HALF_PERIOD system cycles after the strobe.
- R9: rd_valid_o and rd_err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sns_valid_i | input | 1 | Valid flag from the sensor |
| sns_data_i | input | 8 | Sensor data bus; bits [6:0] hold the reading |
| sns_clk_o | output | 1 | Divided clock to the sensor |
| sns_req_o | output | 1 | Measurement request, one sensor period wide |
| rd_valid_o | output | 1 | One-cycle strobe for a good reading |
| rd_data_o | output | 7 | Last good reading |
| rd_err_o | output | 1 | One-cycle strobe when the valid window times out |

## Verification
The bench sweeps all 128 reading values. For each value, the valid delay cycles through 0 to 3 falling edges and bit 7 alternates. This covers every position inside the acceptance window and shows that bit 7 has no effect. Delays of 4, of 5 and of "never" test the window boundary: a delay of 3 must give a reading, while a delay of 4 must give an error. In every wait, the bus carries the inverted value whenever the flag is low. A stray capture would therefore show up as a changed rd_data_o. The bench also applies a reset in the middle of a wait, and measures the request width, the gap to the next request and the clock phases in system cycles.

// File: rtl/sns_cap_pkg.sv
package sns_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } cap_state_e;
endpackage

// File: rtl/sns_clk_div.sv
module sns_clk_div #(
  parameter int HALF_PERIOD = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q, sclk_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sclk_q    <= 1'b0;
      sclk_d1_q <= 1'b0;
    end else begin
      sclk_d1_q <= sclk_q;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = sclk_q & ~sclk_d1_q;
  assign fall_o = ~sclk_q & sclk_d1_q;
endmodule

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sns_cap_fsm.sv
module sns_cap_fsm
  import sns_cap_pkg::*;
#(
  parameter int RD_W     = 7,
  parameter int MAX_WAIT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            vld_s_i,
  input  logic [RD_W-1:0] dat_s_i,
  output logic            req_o,
  output logic            rd_valid_o,
  output logic [RD_W-1:0] rd_data_o,
  output logic            rd_err_o
);
  localparam int WCW = $clog2(MAX_WAIT + 1);
  localparam logic [WCW-1:0] WLAST = WCW'(MAX_WAIT - 1);

  cap_state_e     state_q;
  logic [WCW-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wcnt_q     <= '0;
      req_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_err_o   <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      rd_err_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall_i) begin
          req_o   <= 1'b1;
          state_q <= ST_REQ;
        end
        ST_REQ: if (fall_i) begin
          // exactly one sensor period high
          req_o   <= 1'b0;
          wcnt_q  <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (rise_i) begin
          if (vld_s_i) begin
            rd_data_o  <= dat_s_i;
            rd_valid_o <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (wcnt_q == WLAST) begin
            rd_err_o <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_capture_ctrl.sv
module sensor_capture_ctrl #(
  parameter int SYS_CLK_HZ  = 50_000_000,
  parameter int MAX_SNS_HZ  = 100,
  parameter int HALF_PERIOD = 500_000,
  parameter int BUS_W       = 8,
  parameter int RD_W        = 7,
  parameter int MAX_WAIT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sns_valid_i,
  input  logic [BUS_W-1:0] sns_data_i,
  output logic             sns_clk_o,
  output logic             sns_req_o,
  output logic             rd_valid_o,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             rd_err_o
);
  localparam int SW = RD_W + 1;

  if (HALF_PERIOD < 2 || SYS_CLK_HZ > MAX_SNS_HZ * 2 * HALF_PERIOD) begin : g_rate_bad
    $error("sensor clock rate exceeds MAX_SNS_HZ");
  end

  logic          sclk_rise, sclk_fall;
  logic [SW-1:0] sync_q;
  logic          unused_hi;

  assign unused_hi = ^sns_data_i[BUS_W-1:RD_W];

  sns_clk_div #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_o (sns_clk_o),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  sync_stage #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sns_valid_i, sns_data_i[RD_W-1:0]}),
    .q_o    (sync_q)
  );

  sns_cap_fsm #(.RD_W(RD_W), .MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .vld_s_i    (sync_q[SW-1]),
    .dat_s_i    (sync_q[RD_W-1:0]),
    .req_o      (sns_req_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_err_o   (rd_err_o)
  );
endmodule

// File: rtl/sensor_capture_chk.sv
module sensor_capture_chk #(
  parameter int HALF_PERIOD = 500_000,
  parameter int RD_W        = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sns_req_i,
  input logic            fall_i,
  input logic            rd_valid_i,
  input logic            rd_err_i,
  input logic [RD_W-1:0] rd_data_i
);
  logic [31:0] req_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_len_q <= '0;
    else if (sns_req_i) req_len_q <= req_len_q + 1;
    else req_len_q <= '0;
  end

  a_r3_req_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sns_req_i) || $fell(sns_req_i)) |-> $past(fall_i));

  a_r3_req_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sns_req_i) |-> (req_len_q == 32'(2 * HALF_PERIOD)));

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> !rd_valid_i);

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_i |=> !rd_err_i);

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_i) |-> rd_valid_i);

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_i && rd_err_i));
endmodule

bind sensor_capture_ctrl sensor_capture_chk #(
  .HALF_PERIOD(HALF_PERIOD), .RD_W(RD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sns_req_i  (sns_req_o),
  .fall_i     (sclk_fall),
  .rd_valid_i (rd_valid_o),
  .rd_err_i   (rd_err_o),
  .rd_data_i  (rd_data_o)
);

// File: tb/sim_sensor_capture_ctrl.sv
module sim_sensor_capture_ctrl;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] dat = 8'h00;
  logic       sclk, req, rd_valid, rd_err;
  logic [6:0] rd_data;

  int  n_chk = 0, n_err = 0;
  bit  done = 0, mon_on = 0;
  logic [6:0] last_good = '0;

  always #2 clk = ~clk;

  sensor_capture_ctrl #(
    .SYS_CLK_HZ(800), .MAX_SNS_HZ(100), .HALF_PERIOD(H)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sns_valid_i(vld), .sns_data_i(dat),
    .sns_clk_o(sclk), .sns_req_o(req), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_err_o(rd_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1: every full sensor-clock phase lasts H system cycles
  initial begin : sclk_mon
    int run;
    logic last;
    run = -1000; last = 1'b0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin run = -1000; last = sclk; end
      else if (sclk == last) run++;
      else begin
        if (run > 0) check(run == H, "R1 sensor clock phase", run, H);
        run = 1; last = sclk;
      end
    end
  end

  task automatic reset_and_first_req(input string tag);
    int n;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(req == 0 && sclk == 0 && rd_valid == 0 && rd_err == 0, {tag, " R2 idle outputs"},
          {req, sclk, rd_valid, rd_err}, 0);
    check(rd_data == 0, {tag, " R2 reading cleared"}, rd_data, 0);
    rst_ni = 1'b1;
    n = 0;
    while (!req && n < 100) begin @(negedge clk); n++; end
    check(n == 2 * H + 1, {tag, " R2 first request timing"}, n, 2 * H + 1);
  endtask

  // delay d: valid driven after d sensor-clock falls past the request drop (d<0: never)
  task automatic measure(input int d, input logic [6:0] val, input logic b7, input bit good);
    int n, fc, it, nv, ne, tout;
    logic [6:0] got;
    logic pclk;
    it = 0;
    while (!req && it < 400) begin @(negedge clk); it++; end
    n = 0;
    while (req && n < 400) begin n++; @(negedge clk); end
    check(n == 2 * H, "R3 request width", n, 2 * H);
    fc = 0; nv = 0; ne = 0; tout = -1000; got = '0; pclk = sclk;
    dat = {~b7, ~val};
    if (d == 0) begin vld = 1'b1; dat = {b7, val}; end
    it = 0;
    while (!req && it < 600) begin
      @(negedge clk); it++;
      if (pclk && !sclk) begin
        fc++;
        if (fc == d) begin vld = 1'b1; dat = {b7, val}; end
        else if (vld) begin vld = 1'b0; dat = {~b7, ~val}; end
      end
      pclk = sclk;
      if (rd_valid) begin nv++; got = rd_data; tout = it; end
      if (rd_err) begin ne++; tout = it; end
    end
    vld = 1'b0;
    check(req == 1, "R8 next request issued", req, 1);
    check(it - tout == H, "R8 gap strobe to next request", it - tout, H);
    if (good) begin
      check(nv == 1 && ne == 0, "R4 single good strobe", nv * 10 + ne, 10);
      check(got == val, "R4 R5 captured reading", got, val);
      last_good = val;
    end else begin
      check(ne == 1 && nv == 0, "R7 single timeout strobe", ne * 10 + nv, 10);
      check(rd_data == last_good, "R6 reading held", rd_data, last_good);
    end
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    reset_and_first_req("init");
    mon_on = 1;
    // sweep all values, all in-window delays, bit 7 alternating
    for (int v = 0; v < 128; v++)
      measure(v % 4, 7'(v), v[0], 1'b1);
    // window boundary and bad readings
    measure(3, 7'h2A, 1'b1, 1'b1);
    measure(4, 7'h11, 1'b0, 1'b0);
    measure(5, 7'h22, 1'b1, 1'b0);
    measure(-1, 7'h33, 1'b0, 1'b0);
    measure(0, 7'h55, 1'b1, 1'b1);
    measure(-1, 7'h0F, 1'b1, 1'b0);
    // reset in the middle of a wait
    while (!req) @(negedge clk);
    while (req) @(negedge clk);
    repeat (10) @(negedge clk);
    mon_on = 0;
    reset_and_first_req("midrun");
    mon_on = 1;
    last_good = '0;
    measure(1, 7'h6C, 1'b0, 1'b1);
    measure(-1, 7'h01, 1'b1, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule